// File: doc/BRIEF.md
# Two-Clock Real-Time Counter with Prescaler

This block is a 16-bit real-time counter that runs in its own slow counting clock, separate from the peripheral clock that software uses to reach it. A 3-bit selection divides the counting clock before it advances the counter. The counter wraps to zero when it reaches the period value. It also watches for the compare value. Each of these two matches sets a sticky interrupt flag and sends a one-cycle event pulse into the peripheral clock domain.

All register writes are made in the peripheral domain. They travel to the counting domain through a toggle handshake, and a busy output stays high while a write is in flight. The running count comes back through a second handshake, so a read never returns a torn value.

When the period is 0 or 1, matches occur faster than a pulse can cross between the clocks. The event outputs are therefore thinned in a fixed pattern in that case. The interrupt flags are not thinned.

Top module: `rtc_async_counter`

## Requirements
- R1: After reset, the registers read back as follows: control 0 (stopped), period 0xFFFF, compare 0, count 0 and flags 0. `busy`, both interrupt outputs and both event outputs are low.
- R2: Address 0 is the control register. Its bits [2:0] hold the prescaler selection. Its bits [15:3] always read as zero and ignore writes, so writing 0xFFFF reads back as 0x0007.
- R3: The selection codes 1 to 7 divide the counting clock by 1, 2, 8, 16, 64, 256 and 1024. With period P ≥ 2, overflow events are spaced (P+1)·D counting-clock cycles apart.
- R4: Selection code 0 stops the counter. The count holds its value and no event is produced.
- R5: On a divided tick where count equals period (address 2), the count goes to zero and the overflow flag and event fire. The event is thinned as set out in R7 and R8.
- R6: On a divided tick where count equals compare (address 3), the compare flag and event fire. With period 9, compare 4 and divide-by-2, each overflow event comes 10 counting-clock cycles after the compare event before it.
- R7: With period 0, the events fire on only every third match.
- R8: With period 1, the events fire on only every second match.
- R9: With period 2 or more, an event fires on every match.
- R10: A write to addresses 0 to 3 raises `busy` from the next peripheral cycle until the value has been applied in the counting domain. A write to these addresses made while `busy` is high is dropped.
- R11: Address 4 holds the flags: bit 0 is overflow and bit 1 is compare. A flag stays set until a 1 is written to its bit. A new match in the same cycle as a clear wins over the clear.
- R12: Reading address 1 returns a coherent copy of the count. Writing address 1 loads the count.
- R13: `ev_ovf` and `ev_cmp` are pulses one peripheral cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral (register) clock |
| rclk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 count, 2 period, 3 compare, 4 flags |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address, same map as the write address |
| rd_data | output | 16 | Combinational read data |
| busy | output | 1 | A synchronized write is still in flight |
| irq_ovf | output | 1 | Sticky overflow flag |
| irq_cmp | output | 1 | Sticky compare flag |
| ev_ovf | output | 1 | Overflow event pulse, peripheral domain |
| ev_cmp | output | 1 | Compare event pulse, peripheral domain |

## Verification
Each result arrives after a different delay:
- Control, period and compare read back on the very next peripheral cycle.
- `busy` is due one cycle after the write strobe. It falls only after a round trip of two synchronizer stages in each clock, so the bench polls it rather than counting cycles.
- An event reaches the outputs after a fixed synchronizer delay plus up to one peripheral cycle of phase jitter. For this reason the bench does not time events absolutely. It measures the spacing between consecutive events, and the spacing from a compare event to the next overflow event, and accepts 25 ns of tolerance against the spacing it predicts from the period, the divide ratio and the thinning rule.
- A loaded count is read only after a wait of well over the handshake round trip.
- A flag clear is checked on the cycle after the write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int CNT_W  = 16;
    localparam int DIV_W  = 10;
    localparam int ADDR_W = 3;
    localparam int SYNC_N = 2;
    localparam int NCH    = 2;   // channel 0: overflow, channel 1: compare

    typedef enum logic [2:0] {
        PS_OFF   = 3'd0,
        PS_D1    = 3'd1,
        PS_D2    = 3'd2,
        PS_D8    = 3'd3,
        PS_D16   = 3'd4,
        PS_D64   = 3'd5,
        PS_D256  = 3'd6,
        PS_D1024 = 3'd7
    } presc_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL    = 3'd0,
        RA_COUNT   = 3'd1,
        RA_PERIOD  = 3'd2,
        RA_COMPARE = 3'd3,
        RA_FLAGS   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  data;
    } wr_cmd_t;

    // log2 of the divide ratio for each selection
    function automatic int presc_shift(presc_e s);
        case (s)
            PS_D2:    return 1;
            PS_D8:    return 3;
            PS_D16:   return 4;
            PS_D64:   return 6;
            PS_D256:  return 8;
            PS_D1024: return 10;
            default:  return 0;
        endcase
    endfunction

    // matches to skip after each emitted event
    function automatic logic [1:0] thin_reload(logic [CNT_W-1:0] per);
        if (per == '0)               return 2'd2;
        else if (per == CNT_W'(1))   return 2'd1;
        else                         return 2'd0;
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic   rclk,
    input  logic   rst,
    input  logic   restart,
    input  presc_e sel,
    output logic   tick
);
    logic [DW-1:0] div_q;
    logic [DW:0]   one_hot;
    logic [DW-1:0] mask;

    always_comb begin
        one_hot = (DW+1)'(1) << presc_shift(sel);
        mask    = DW'(one_hot - 1'b1);
    end

    always_ff @(posedge rclk) begin
        if (rst || restart)      div_q <= '0;
        else if (sel != PS_OFF)  div_q <= div_q + 1'b1;
    end

    assign tick = (sel != PS_OFF) && ((div_q & mask) == mask);
endmodule

// File: rtl/rtc_thin.sv
module rtc_thin (
    input  logic       rclk,
    input  logic       rst,
    input  logic       hit,
    input  logic [1:0] reload,
    output logic       emit
);
    logic [1:0] skip_q;

    assign emit = hit && (skip_q == 2'd0);

    always_ff @(posedge rclk) begin
        if (rst)
            skip_q <= 2'd0;
        else if (hit)
            skip_q <= (skip_q == 2'd0) ? reload : skip_q - 1'b1;
    end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
(
    input  logic             rclk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ld_cnt,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic [NCH-1:0]   flag_tog,
    output logic [NCH-1:0]   ev_tog
);
    logic [NCH-1:0] hit;
    logic [NCH-1:0] emit;
    logic [1:0]     reload;

    assign hit[0] = tick && (cnt == per);
    assign hit[1] = tick && (cnt == cmp);
    assign reload = thin_reload(per);

    always_ff @(posedge rclk) begin
        if (rst)          cnt <= '0;
        else if (ld_cnt)  cnt <= ld_val;
        else if (hit[0])  cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        rtc_thin u_thin (
            .rclk   (rclk),
            .rst    (rst),
            .hit    (hit[i]),
            .reload (reload),
            .emit   (emit[i])
        );

        always_ff @(posedge rclk) begin
            if (rst) begin
                flag_tog[i] <= 1'b0;
                ev_tog[i]   <= 1'b0;
            end else begin
                flag_tog[i] <= flag_tog[i] ^ hit[i];
                ev_tog[i]   <= ev_tog[i] ^ emit[i];
            end
        end
    end
endmodule

// File: rtl/rtc_pulse_sync.sv
module rtc_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_in,
    output logic pulse
);
    logic [STAGES-1:0] s_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q    <= '0;
            prev_q <= 1'b0;
        end else begin
            s_q    <= {s_q[STAGES-2:0], tog_in};
            prev_q <= s_q[STAGES-1];
        end
    end

    assign pulse = s_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/rtc_async_counter.sv
module rtc_async_counter
    import rtc_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_N
) (
    input  logic              pclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              busy,
    output logic              irq_ovf,
    output logic              irq_cmp,
    output logic              ev_ovf,
    output logic              ev_cmp
);
    localparam int S = SYNC_STAGES;

    // ---------------- peripheral domain ----------------
    presc_e            ctrl_sh;
    logic [CNT_W-1:0]  per_sh, cmp_sh, cnt_rd;
    logic [NCH-1:0]    flags, flag_pulse, ev_pulse, ev_q, clr;
    wr_cmd_t           cmd_hold;
    logic              req_tog, cnt_seen, accept;
    logic [S-1:0]      ack_s, snap_s;

    // ---------------- counting domain ----------------
    logic [S-1:0]      req_s, snap_ack_s;
    logic              req_seen, apply, ld_cnt, restart, tick, snap_tog;
    presc_e            ctrl_r;
    logic [CNT_W-1:0]  per_r, cmp_r, cnt, snap_val;
    logic [NCH-1:0]    flag_tog, ev_tog;

    assign busy   = req_tog ^ ack_s[S-1];
    assign accept = wr_en && !busy && (wr_addr <= ADDR_W'(RA_COMPARE));
    assign clr    = (wr_en && wr_addr == ADDR_W'(RA_FLAGS)) ? wr_data[NCH-1:0] : '0;

    always_ff @(posedge pclk) begin
        if (rst) begin
            ctrl_sh  <= PS_OFF;
            per_sh   <= '1;
            cmp_sh   <= '0;
            cmd_hold <= '0;
            req_tog  <= 1'b0;
            ack_s    <= '0;
            snap_s   <= '0;
            cnt_seen <= 1'b0;
            cnt_rd   <= '0;
            flags    <= '0;
            ev_q     <= '0;
        end else begin
            ack_s  <= {ack_s[S-2:0], req_seen};
            snap_s <= {snap_s[S-2:0], snap_tog};
            if (snap_s[S-1] != cnt_seen) begin
                cnt_rd   <= snap_val;
                cnt_seen <= snap_s[S-1];
            end
            if (accept) begin
                cmd_hold <= '{addr: wr_addr, data: wr_data};
                req_tog  <= ~req_tog;
                case (wr_addr)
                    RA_CTRL:    ctrl_sh <= presc_e'(wr_data[2:0]);
                    RA_PERIOD:  per_sh  <= wr_data;
                    RA_COMPARE: cmp_sh  <= wr_data;
                    default: ;
                endcase
            end
            flags <= (flags & ~clr) | flag_pulse;
            ev_q  <= ev_pulse;
        end
    end

    always_comb begin
        case (rd_addr)
            RA_CTRL:    rd_data = {{(CNT_W-3){1'b0}}, ctrl_sh};
            RA_COUNT:   rd_data = cnt_rd;
            RA_PERIOD:  rd_data = per_sh;
            RA_COMPARE: rd_data = cmp_sh;
            RA_FLAGS:   rd_data = {{(CNT_W-NCH){1'b0}}, flags};
            default:    rd_data = '0;
        endcase
    end

    assign irq_ovf = flags[0];
    assign irq_cmp = flags[1];
    assign ev_ovf  = ev_q[0];
    assign ev_cmp  = ev_q[1];

    // write application in the counting domain
    assign apply   = req_s[S-1] ^ req_seen;
    assign ld_cnt  = apply && (cmd_hold.addr == ADDR_W'(RA_COUNT));
    assign restart = apply && (cmd_hold.addr == ADDR_W'(RA_CTRL));

    always_ff @(posedge rclk) begin
        if (rst) begin
            req_s      <= '0;
            req_seen   <= 1'b0;
            ctrl_r     <= PS_OFF;
            per_r      <= '1;
            cmp_r      <= '0;
            snap_ack_s <= '0;
            snap_tog   <= 1'b0;
            snap_val   <= '0;
        end else begin
            req_s      <= {req_s[S-2:0], req_tog};
            snap_ack_s <= {snap_ack_s[S-2:0], cnt_seen};
            if (apply) begin
                req_seen <= ~req_seen;
                case (cmd_hold.addr)
                    RA_CTRL:    ctrl_r <= presc_e'(cmd_hold.data[2:0]);
                    RA_PERIOD:  per_r  <= cmd_hold.data;
                    RA_COMPARE: cmp_r  <= cmd_hold.data;
                    default: ;
                endcase
            end
            if (snap_tog == snap_ack_s[S-1]) begin
                snap_val <= cnt;
                snap_tog <= ~snap_tog;
            end
        end
    end

    rtc_prescaler u_presc (
        .rclk    (rclk),
        .rst     (rst),
        .restart (restart),
        .sel     (ctrl_r),
        .tick    (tick)
    );

    rtc_core u_core (
        .rclk     (rclk),
        .rst      (rst),
        .tick     (tick),
        .ld_cnt   (ld_cnt),
        .ld_val   (cmd_hold.data),
        .per      (per_r),
        .cmp      (cmp_r),
        .cnt      (cnt),
        .flag_tog (flag_tog),
        .ev_tog   (ev_tog)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_sync
        rtc_pulse_sync #(.STAGES(S)) u_flag_sync (
            .clk    (pclk),
            .rst    (rst),
            .tog_in (flag_tog[i]),
            .pulse  (flag_pulse[i])
        );
        rtc_pulse_sync #(.STAGES(S)) u_ev_sync (
            .clk    (pclk),
            .rst    (rst),
            .tog_in (ev_tog[i]),
            .pulse  (ev_pulse[i])
        );
    end
endmodule

// File: rtl/rtc_async_counter_sva.sv
module rtc_async_counter_sva (
    input logic        pclk,
    input logic        rst,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [15:0] wr_data,
    input logic [2:0]  rd_addr,
    input logic [15:0] rd_data,
    input logic        busy,
    input logic        irq_ovf,
    input logic        irq_cmp,
    input logic        ev_ovf,
    input logic        ev_cmp,
    input logic [1:0]  flag_pulse
);
    a_r2_ctrl_upper_zero: assert property (@(posedge pclk) disable iff (rst)
        (rd_addr == 3'd0) |-> (rd_data[15:3] == 13'd0));

    a_r13_ovf_pulse_single: assert property (@(posedge pclk) disable iff (rst)
        ev_ovf |=> !ev_ovf);

    a_r13_cmp_pulse_single: assert property (@(posedge pclk) disable iff (rst)
        ev_cmp |=> !ev_cmp);

    a_r10_busy_after_write: assert property (@(posedge pclk) disable iff (rst)
        $rose(busy) |-> $past(wr_en));

    a_r5_ovf_event_flagged: assert property (@(posedge pclk) disable iff (rst)
        ev_ovf |-> irq_ovf);

    a_r6_cmp_event_flagged: assert property (@(posedge pclk) disable iff (rst)
        ev_cmp |-> irq_cmp);

    a_r11_ovf_set_source: assert property (@(posedge pclk) disable iff (rst)
        $rose(irq_ovf) |-> $past(flag_pulse[0]));

    a_r11_ovf_clear: assert property (@(posedge pclk) disable iff (rst)
        $past(wr_en && wr_addr == 3'd4 && wr_data[0] && !flag_pulse[0]) |-> !irq_ovf);
endmodule

bind rtc_async_counter rtc_async_counter_sva u_sva (
    .pclk       (pclk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .busy       (busy),
    .irq_ovf    (irq_ovf),
    .irq_cmp    (irq_cmp),
    .ev_ovf     (ev_ovf),
    .ev_cmp     (ev_cmp),
    .flag_pulse (flag_pulse)
);

// File: tb/test_rtc_async_counter.sv
`timescale 1ns/1ps
module test_rtc_async_counter;
    localparam real TR  = 73.0;   // counting clock period, unrelated to 20 ns
    localparam real TOL = 25.0;

    logic        pclk = 1'b0, rclk = 1'b0, rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        busy, irq_ovf, irq_cmp, ev_ovf, ev_cmp;

    int nchk = 0, nerr = 0;

    always #10 pclk = ~pclk;
    always #(TR/2.0) rclk = ~rclk;

    rtc_async_counter i_rtc_async_counter (
        .pclk(pclk), .rclk(rclk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .irq_ovf(irq_ovf), .irq_cmp(irq_cmp), .ev_ovf(ev_ovf), .ev_cmp(ev_cmp)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge pclk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge pclk);
        wr_en = 1'b0;
        while (busy) @(negedge pclk);
    endtask

    task automatic rd(input int a, output int v);
        @(negedge pclk);
        rd_addr = 3'(a);
        #1 v = int'(rd_data);
    endtask

    // stop, zero the count, set period/compare, then start
    task automatic cfg(input int per, input int cmp, input int sel);
        wr(0, 0); wr(1, 0); wr(2, per); wr(3, cmp); wr(0, sel);
    endtask

    task automatic wait_ev(input bit use_cmp, output real t);
        do @(negedge pclk); while (!(use_cmp ? ev_cmp : ev_ovf));
        t = $realtime;
        @(negedge pclk);
        check(!(use_cmp ? ev_cmp : ev_ovf), "R13 pulse width", 2, 1);
    endtask

    task automatic measure(input bit use_cmp, input int nint, input real exp_ns, input string req);
        real t0, t1;
        wait_ev(use_cmp, t0);      // first event after reconfiguration is discarded
        for (int i = 0; i < nint; i++) begin
            wait_ev(use_cmp, t1);
            check((t1 - t0 > exp_ns - TOL) && (t1 - t0 < exp_ns + TOL), req,
                  $rtoi(t1 - t0), $rtoi(exp_ns));
            t0 = t1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge pclk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int v, v2, evc;
        real ta, tb;
        int divs [7] = '{1, 2, 8, 16, 64, 256, 1024};

        repeat (12) @(posedge rclk);
        @(negedge pclk) rst = 1'b0;

        // R1 reset state
        rd(0, v); check(v == 0, "R1 ctrl", v, 0);
        rd(1, v); check(v == 0, "R1 count", v, 0);
        rd(2, v); check(v == 16'hFFFF, "R1 period", v, 16'hFFFF);
        rd(3, v); check(v == 0, "R1 compare", v, 0);
        rd(4, v); check(v == 0, "R1 flags", v, 0);
        check({busy, irq_ovf, irq_cmp, ev_ovf, ev_cmp} == 5'b0, "R1 outputs",
              int'({busy, irq_ovf, irq_cmp, ev_ovf, ev_cmp}), 0);

        // R2 reserved control bits
        wr(0, 16'hFFFF); rd(0, v); check(v == 7, "R2 ctrl readback", v, 7);
        wr(0, 0);

        // R10 busy and dropped write
        @(negedge pclk); wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'h0010;
        @(negedge pclk); check(busy == 1'b1, "R10 busy raised", int'(busy), 1);
        wr_data = 16'h0020;
        @(negedge pclk); wr_en = 1'b0;
        while (busy) @(negedge pclk);
        rd(2, v); check(v == 16'h0010, "R10 write while busy dropped", v, 16'h0010);

        // R12 count load and coherent readback
        wr(1, 16'h1234);
        repeat (150) @(negedge pclk);
        rd(1, v); check(v == 16'h1234, "R12 count load", v, 16'h1234);

        // R4 stopped: count holds, no events
        evc = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge pclk); if (ev_ovf || ev_cmp) evc++;
        end
        rd(1, v2); check(v2 == v, "R4 count holds when stopped", v2, v);
        check(evc == 0, "R4 no events when stopped", evc, 0);

        // R3 R5 divide ratios, period 2: spacing 3*D cycles
        for (int s = 1; s <= 7; s++) begin
            cfg(2, 0, s);
            measure(1'b0, 2, 3.0 * divs[s-1] * TR, $sformatf("R3 R5 divide sel=%0d", s));
        end

        // R7 period 0: every third match
        cfg(0, 0, 1);
        measure(1'b0, 3, 3.0 * TR, "R7 ovf thinning period 0");
        measure(1'b1, 2, 3.0 * TR, "R7 cmp thinning period 0");

        // R8 period 1: every second match (matches every 2 cycles)
        cfg(1, 0, 1);
        measure(1'b0, 3, 4.0 * TR, "R8 ovf thinning period 1");

        // R9 period 2: every match, compare too
        cfg(2, 1, 1);
        measure(1'b1, 3, 3.0 * TR, "R9 cmp every match period 2");

        // R6 compare-to-overflow spacing: period 9, compare 4, /2
        cfg(9, 4, 2);
        measure(1'b1, 2, 20.0 * TR, "R6 compare interval");
        wait_ev(1'b1, ta);
        wait_ev(1'b0, tb);
        check((tb - ta > 10.0 * TR - TOL) && (tb - ta < 10.0 * TR + TOL),
              "R6 compare to overflow", $rtoi(tb - ta), $rtoi(10.0 * TR));

        // R11 sticky flags and write-one-to-clear
        wr(0, 0);
        repeat (20) @(negedge pclk);
        check(irq_ovf && irq_cmp, "R11 flags sticky", int'({irq_ovf, irq_cmp}), 3);
        @(negedge pclk); wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'h0001;
        @(negedge pclk); wr_en = 1'b0;
        check(!irq_ovf && irq_cmp, "R11 clear overflow only",
              int'({irq_ovf, irq_cmp}), 1);
        rd(4, v); check(v == 2, "R11 flag register", v, 2);
        @(negedge pclk); wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'h0002;
        @(negedge pclk); wr_en = 1'b0;
        rd(4, v); check(v == 0, "R11 clear compare", v, 0);

        summary();
        $finish;
    end
endmodule